// File: doc/BRIEF.md
# Shared Clock Settling Timer and Reference Divider

This block sits inside a clock generator. It sees two clock sources as single-cycle enable strobes on one system clock: `ext_tick` for the external clock and `base_tick` for the slow internal base clock. A single long counter does two jobs.

When the external generator is switched on, the counter counts external ticks as a start-up timer. It runs for 16 ticks for a plain external clock and 4096 ticks for a crystal. When that count completes, the block raises `ext_stable`. From then on, the same counter slows one of the two sources into a reference strobe for a clock monitor. A fixed divide-by-four stage sits on each reference path.

If the monitor reports the external clock as inactive, the flag drops and the counter returns to timer duty. Configuration is captured only while the generator is off.

Top module: `scd_ref_divider`

## Requirements
- R1: While `gen_en` is low, `ext_stable` is 0 and neither strobe pulses. Any partial count is discarded, so after `gen_en` rises again the settling count starts over from zero.
- R2: With `cfg_xtal` = 0, `ext_stable` stays 0 after 15 external ticks. It reads 1 in the cycle after the register edge that samples the 16th tick.
- R3: With `cfg_xtal` = 1, `ext_stable` stays 0 after 4095 external ticks and reads 1 after the 4096th tick.
- R4: While `ext_stable` is 0, `base_tick` does not advance the settling count, whatever the configuration bits hold.
- R5: While `ext_stable` is 0, neither `eref_strobe` nor `iref_strobe` pulses.
- R6: When stable with `cfg_slow_ext` = 0, `eref_strobe` pulses once per 512 external ticks (128×4) and `iref_strobe` pulses once per 4 base ticks.
- R7: When stable with `cfg_slow_ext` = 1, `eref_strobe` pulses once per 4 external ticks. `iref_strobe` pulses once per 16384 base ticks (4096×4) when `cfg_xtal` = 1, and once per 64 base ticks (16×4) when `cfg_xtal` = 0.
- R8: A `mon_inactive` pulse while stable clears `ext_stable` at the next edge. A complete new settling count is then needed before the flag sets again.
- R9: A `mon_inactive` pulse while not yet stable has no effect on the settling count.
- R10: Changes to `cfg_slow_ext` or `cfg_xtal` while `gen_en` is high are ignored. The values held in the last cycle with `gen_en` low stay in force.
- R11: Each reference strobe is a single-cycle pulse and is never high in two consecutive cycles.
- R12: Once set, `ext_stable` stays set until `gen_en` goes low or `mon_inactive` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_en | input | 1 | External generator enable; low means off or stopped |
| ext_tick | input | 1 | One-cycle strobe per external clock cycle |
| base_tick | input | 1 | One-cycle strobe per internal base clock cycle |
| cfg_slow_ext | input | 1 | 1: external clock is slow, so the long divider goes on the internal path |
| cfg_xtal | input | 1 | 1: crystal source, which uses the 4096 settling length |
| mon_inactive | input | 1 | Pulse from the clock monitor: external clock found inactive |
| ext_stable | output | 1 | External clock has completed its settling count |
| eref_strobe | output | 1 | External reference strobe, one cycle wide |
| iref_strobe | output | 1 | Internal reference strobe, one cycle wide |

## Verification
The hardest case to reach is the internal reference at its slowest ratio. This needs the crystal setting, the full 4096-tick settling count, and then more than 16384 base ticks before a single `iref_strobe` appears. The table-driven phase gets there by asserting a base tick every cycle for 32768 cycles after the flag sets, and checks for exactly two strobes. Timer fall-back is reached by pulsing `mon_inactive` after the flag has set. The bench then proves that 15 more external ticks are not enough to set the flag again.

// File: rtl/scd_pkg.sv
// Package for the shared settling/reference divider.
// Holds the operating-mode type that selects the long counter's source and
// terminal count. Assumes nothing beyond plain SystemVerilog.
package scd_pkg;

    typedef enum logic [1:0] {
        MODE_SETTLE   = 2'd0,  // counting external ticks toward the stable flag
        MODE_FAST_EXT = 2'd1,  // stable, long divider on the external path
        MODE_SLOW_EXT = 2'd2   // stable, long divider on the internal path
    } scd_mode_e;

endpackage

// File: rtl/scd_cfg_hold.sv
// Configuration holder.
// Captures the two mode bits each cycle while the generator is disabled and
// freezes them while it runs, so no ratio changes in the middle of a count.
// Assumes the bits are quasi-static relative to clk.
module scd_cfg_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_en,
    input  logic slow_in,
    input  logic xtal_in,
    output logic slow_q,
    output logic xtal_q
);

    // Track the configuration inputs only while the generator is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_q <= 1'b0;
            xtal_q <= 1'b0;
        end else if (!gen_en) begin
            slow_q <= slow_in;
            xtal_q <= xtal_in;
        end
    end

    // R10: while enabled, the held values never move.
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gen_en) |-> ($stable(slow_q) && $stable(xtal_q)));

endmodule

// File: rtl/scd_long_div.sv
// Long modulo counter shared by settling timer and reference divider.
// Counts tick_i pulses from 0 up to term_i-1. wrap_o is high in the same cycle
// as the tick that completes a full term. clr_i restarts the count from zero.
// Assumes term_i >= 1 and that term_i changes only together with clr_i.
module scd_long_div #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic [CW:0]   term_i,
    output logic          wrap_o
);

    logic [CW-1:0] cnt;

    // Detect the tick that finishes the current term.
    assign wrap_o = tick_i && ({1'b0, cnt} == term_i - 1'b1);

    // Advance, wrap or restart the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)  cnt <= '0;
        else if (wrap_o)      cnt <= '0;
        else if (tick_i)      cnt <= cnt + 1'b1;
    end

    // R2, R3: the count never reaches or passes its terminal value.
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt} < term_i));

endmodule

// File: rtl/scd_prediv.sv
// Fixed pre-divider on a reference path.
// Emits one registered single-cycle pulse for every DIV input pulses.
// clr_i drops any partial count and any pending pulse.
// Assumes DIV >= 2.
module scd_prediv #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic in_i,
    output logic pulse_o
);

    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt;

    // Count input pulses and register the strobe on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt     <= '0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= in_i && (cnt == LAST);
            if (in_i) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // R11: a strobe never lasts two cycles.
    p_single_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/scd_ref_divider.sv
// Shared clock settling timer and monitor reference divider (top).
// One long counter first times external-clock settling (SHORT_LEN or LONG_LEN
// external ticks), then divides one of the two sources for the clock monitor.
// Each reference path also carries a fixed PRE_DIV stage. A monitor inactivity
// pulse returns the block to settling. Assumes ext_tick and base_tick are
// synchronous one-cycle strobes.
module scd_ref_divider #(
    parameter int SHORT_LEN = 16,
    parameter int LONG_LEN  = 4096,
    parameter int EXT_LEN   = 128,
    parameter int PRE_DIV   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_en,
    input  logic ext_tick,
    input  logic base_tick,
    input  logic cfg_slow_ext,
    input  logic cfg_xtal,
    input  logic mon_inactive,
    output logic ext_stable,
    output logic eref_strobe,
    output logic iref_strobe
);
    import scd_pkg::*;

    localparam int CW = $clog2(LONG_LEN);
    localparam logic [CW:0] TERM_SHORT = (CW+1)'(SHORT_LEN);
    localparam logic [CW:0] TERM_LONG  = (CW+1)'(LONG_LEN);
    localparam logic [CW:0] TERM_EXT   = (CW+1)'(EXT_LEN);

    logic        slow_q, xtal_q;
    logic        stable_d, restart, wrap;
    logic        long_tick, eref_in, iref_in;
    logic [CW:0] term, settle_term;
    scd_mode_e   mode;

    scd_cfg_hold cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .gen_en  (gen_en),
        .slow_in (cfg_slow_ext),
        .xtal_in (cfg_xtal),
        .slow_q  (slow_q),
        .xtal_q  (xtal_q)
    );

    // Pick the operating mode from the flag and held configuration.
    always_comb begin
        if (!ext_stable)  mode = MODE_SETTLE;
        else if (slow_q)  mode = MODE_SLOW_EXT;
        else              mode = MODE_FAST_EXT;
    end

    assign settle_term = xtal_q ? TERM_LONG : TERM_SHORT;

    // Route sources and terminal count per mode.
    always_comb begin
        term      = settle_term;
        long_tick = ext_tick;
        eref_in   = 1'b0;
        iref_in   = 1'b0;
        case (mode)
            MODE_FAST_EXT: begin
                term    = TERM_EXT;
                eref_in = wrap;
                iref_in = base_tick;
            end
            MODE_SLOW_EXT: begin
                long_tick = base_tick;
                eref_in   = ext_tick;
                iref_in   = wrap;
            end
            default: ;
        endcase
    end

    // Next value of the stable flag.
    always_comb begin
        if (!gen_en)                      stable_d = 1'b0;
        else if (ext_stable && mon_inactive) stable_d = 1'b0;
        else if (!ext_stable && wrap)     stable_d = 1'b1;
        else                              stable_d = ext_stable;
    end

    // Any disable or mode change restarts all counting from zero.
    assign restart = !gen_en || (stable_d != ext_stable);

    // Register the stable flag.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_stable <= 1'b0;
        else        ext_stable <= stable_d;
    end

    scd_long_div #(.CW(CW)) long_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (restart),
        .tick_i (long_tick),
        .term_i (term),
        .wrap_o (wrap)
    );

    // Both reference paths carry the same fixed pre-divider.
    for (genvar g = 0; g < 2; g++) begin : g_ref
        logic p_in, p_out;
        assign p_in = (g == 0) ? eref_in : iref_in;
        scd_prediv #(.DIV(PRE_DIV)) pre_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (restart),
            .in_i    (p_in),
            .pulse_o (p_out)
        );
    end

    assign eref_strobe = g_ref[0].p_out;
    assign iref_strobe = g_ref[1].p_out;

    // R1: a disabled generator clears the flag at the next edge.
    p_off_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !ext_stable);

    // R2: the flag rises only on a completed settling count.
    p_rise_after_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_stable) |-> $past(wrap));

    // R5: no reference strobes while settling.
    p_quiet_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_stable |-> (!eref_strobe && !iref_strobe));

    // R8: monitor inactivity drops the flag.
    p_mon_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_stable && mon_inactive) |=> !ext_stable);

    // R12: the flag holds with no disable and no inactivity report.
    p_hold_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_stable && gen_en && !mon_inactive) |=> ext_stable);

endmodule

// File: tb/scd_ref_divider_tb.sv
module scd_ref_divider_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 4;
    // slow, xtal, ext ticks, base ticks, expected eref, expected iref
    localparam int unsigned VEC [NVEC][6] = '{
        '{0, 0, 1024,    40, 2, 10},
        '{0, 1, 1536,     8, 3,  2},
        '{1, 0,   20,   256, 5,  4},
        '{1, 1,   12, 32768, 3,  2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gen_en = 1'b0, ext_tick = 1'b0, base_tick = 1'b0;
    logic cfg_slow_ext = 1'b0, cfg_xtal = 1'b0, mon_inactive = 1'b0;
    logic ext_stable, eref_strobe, iref_strobe;

    int checks = 0, errors = 0;
    int n_eref = 0, n_iref = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scd_ref_divider dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .gen_en       (gen_en),
        .ext_tick     (ext_tick),
        .base_tick    (base_tick),
        .cfg_slow_ext (cfg_slow_ext),
        .cfg_xtal     (cfg_xtal),
        .mon_inactive (mon_inactive),
        .ext_stable   (ext_stable),
        .eref_strobe  (eref_strobe),
        .iref_strobe  (iref_strobe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Sample outputs at the falling edge, then drive the next tick inputs.
    task automatic cyc(input logic e, input logic b);
        @(negedge clk);
        if (eref_strobe) n_eref++;
        if (iref_strobe) n_iref++;
        ext_tick  = e;
        base_tick = b;
    endtask

    task automatic power_up(input logic slow, input logic xtal);
        gen_en = 1'b0; cfg_slow_ext = slow; cfg_xtal = xtal;
        cyc(0, 0); cyc(0, 0);
        gen_en = 1'b1;
    endtask

    // Settle with base ticks present; check the flag edge and quiet strobes.
    task automatic settle(input int len, input string tag);
        n_eref = 0; n_iref = 0;
        for (int i = 0; i < len - 1; i++) cyc(1, 1);
        cyc(0, 0);
        chk(ext_stable == 1'b0, {tag, " not stable one tick early"}, ext_stable, 0);
        cyc(1, 0); cyc(0, 0);
        chk(ext_stable == 1'b1, {tag, " stable after full count"}, ext_stable, 1);
        chk(n_eref + n_iref == 0, "R5 no strobes while settling", n_eref + n_iref, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cyc(0, 0);
        rst_n = 1'b1;
        cyc(0, 0);
        chk(ext_stable == 0 && eref_strobe == 0 && iref_strobe == 0,
            "R1 reset state", ext_stable, 0);

        // Table-driven ratio checks (R2, R3, R6, R7).
        for (int v = 0; v < NVEC; v++) begin
            int len, steps;
            power_up(VEC[v][0][0], VEC[v][1][0]);
            len = VEC[v][1] != 0 ? 4096 : 16;
            settle(len, VEC[v][1] != 0 ? "R3" : "R2");
            n_eref = 0; n_iref = 0;
            steps = (VEC[v][2] > VEC[v][3]) ? VEC[v][2] : VEC[v][3];
            for (int i = 0; i < steps; i++)
                cyc(i < VEC[v][2], i < VEC[v][3]);
            repeat (3) cyc(0, 0);
            chk(n_eref == VEC[v][4], VEC[v][0] != 0 ? "R7 eref count" : "R6 eref count",
                n_eref, VEC[v][4]);
            chk(n_iref == VEC[v][5], VEC[v][0] != 0 ? "R7 iref count" : "R6 iref count",
                n_iref, VEC[v][5]);
        end

        // R1: disabling clears the flag.
        gen_en = 1'b0; cyc(0, 0); cyc(0, 0);
        chk(ext_stable == 0, "R1 flag clear while disabled", ext_stable, 0);

        // R1: a partial count is lost across a disable.
        power_up(0, 0);
        for (int i = 0; i < 10; i++) cyc(1, 0);
        gen_en = 1'b0; cyc(0, 0); cyc(0, 0);
        gen_en = 1'b1;
        for (int i = 0; i < 15; i++) cyc(1, 0);
        cyc(0, 0);
        chk(ext_stable == 0, "R1 count restarted after disable", ext_stable, 0);
        cyc(1, 0); cyc(0, 0);
        chk(ext_stable == 1, "R1 stable after fresh full count", ext_stable, 1);

        // R8: inactivity drops the flag and forces a new full count.
        mon_inactive = 1'b1; cyc(0, 0);
        mon_inactive = 1'b0; cyc(0, 0);
        chk(ext_stable == 0, "R8 flag cleared by monitor", ext_stable, 0);
        for (int i = 0; i < 15; i++) cyc(1, 0);
        cyc(0, 0);
        chk(ext_stable == 0, "R8 needs full recount", ext_stable, 0);
        cyc(1, 0); cyc(0, 0);
        chk(ext_stable == 1, "R8 stable again after recount", ext_stable, 1);

        // R4: base ticks alone never complete settling.
        power_up(1, 0);
        for (int i = 0; i < 40; i++) cyc(0, 1);
        cyc(0, 0);
        chk(ext_stable == 0, "R4 base ticks ignored while settling", ext_stable, 0);

        // R9 and R10: inactivity and config changes while settling are ignored.
        power_up(0, 0);
        for (int i = 0; i < 5; i++) cyc(1, 0);
        mon_inactive = 1'b1; cfg_xtal = 1'b1;
        cyc(1, 0);
        mon_inactive = 1'b0;
        for (int i = 0; i < 9; i++) cyc(1, 0);
        cyc(0, 0);
        chk(ext_stable == 0, "R9 not stable after 15 ticks", ext_stable, 0);
        cyc(1, 0); cyc(0, 0);
        chk(ext_stable == 1, "R9 R10 stable at 16 despite pulse and config change",
            ext_stable, 1);

        // R11 and R12: prescaler strobes never run two cycles; flag holds.
        begin
            int prev = 0, dbl = 0;
            for (int i = 0; i < 64; i++) begin
                cyc(0, 1);
                if (iref_strobe && prev != 0) dbl++;
                prev = iref_strobe;
            end
            chk(dbl == 0, "R11 single-cycle strobes", dbl, 0);
            chk(ext_stable == 1, "R12 flag held", ext_stable, 1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule